// File: doc/BRIEF.md
# Signed Shift-Add Sequential Multiplier

This block multiplies two two's-complement operands, each `W` bits wide, and returns a signed product of `2W` bits. It works through the multiplier one bit per clock, least significant bit first, inside a single accumulator of `2W+1` bits. The upper `W+1` bits of the accumulator hold the running partial product. The lower `W` bits start out as the multiplier and are shifted out as each step consumes a bit. The adder result is wired into the accumulator one position to the right, so the conditional add and the arithmetic right shift finish in the same cycle. The last step weighs the multiplier's sign bit negatively, so the multiplicand is subtracted instead of added.

To use the block, the caller drives both operands and pulses `start_i` for one cycle while the block is idle. The block samples the operands on that edge. After `W` step cycles it raises `done_o` for a single cycle. The product stays on `product_o` until the next start is accepted.

Top module: `signed_seq_mul`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after reset, `done_o` is 0 and `product_o` is 0.
- R2: For every pair of `W`-bit signed operands, `product_o` equals their signed product, sign-extended into `2W` bits.
- R3: When `start_i` is sampled high by a rising edge while idle, `done_o` goes high right after the `W+1`-th rising edge counted from, and including, that edge. With `W`=4 that is the 5th edge.
- R4: `done_o` is high for exactly one clock cycle per multiplication.
- R5: A `start_i` pulse that arrives while a multiplication is in progress is ignored. The result and the timing of `done_o` are those of the multiplication already running.
- R6: After `done_o`, `product_o` stays unchanged until a new start is accepted.
- R7: Operands are sampled only on the edge that accepts `start_i`. Changes on `mcand_i` and `mplier_i` during the run have no effect on the result.
- R8: The most negative value times itself gives the correct positive product. With `W`=4, 4'b1000 × 4'b1000 gives 8'h40 (+64).
- R9: A multiplier with its sign bit set yields the correct product, because the final step subtracts the multiplicand. Example: 4'b0111 × 4'b1000 = 8'hC8 (−56).
- R10: A negative multiplicand with a positive multiplier keeps its sign through every shift. Example: 4'b1000 × 4'b0111 = 8'hC8, and 4'b1101 × 4'b0101 = 8'hF1 (−15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; honoured only while idle |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| product_o | output | 2W | Signed product |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the cycle-level rules on every clock:
- `done_o` never lasts two cycles.
- A run always begins with its step counter at zero.
- A run cannot be cut short by a new start.
- The accumulator holds whenever no load or step is in progress.
- A load captures the multiplier as it was presented.

Only the bench's scenarios can show the arithmetic itself. They cover the full operand sweep, the sign corner cases such as 1000 × 1000, the latency of exactly `W+1` edges, and the fact that stray starts and changing operands during a run leave the result unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_addsub.sv
// Ripple add/subtract of a sign-extended operand into a W+1 bit partial product
module mul_addsub #(
  parameter int W = 4
) (
  input  logic [W:0]   part_i,
  input  logic [W-1:0] opnd_i,
  input  logic         en_i,
  input  logic         sub_i,
  output logic [W:0]   res_o
);
  logic [W:0] opnd_x;
  logic [W:0] sum;
  logic [W:0] carry;

  assign opnd_x   = {opnd_i[W-1], opnd_i} ^ {(W+1){sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i <= W; i++) begin : g_fa
    assign sum[i] = part_i[i] ^ opnd_x[i] ^ carry[i];
    if (i < W) begin : g_cy
      assign carry[i+1] = (part_i[i] & opnd_x[i]) | (carry[i] & (part_i[i] ^ opnd_x[i]));
    end
  end

  assign res_o = en_i ? sum : part_i;
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign last_o = step_o && (cnt_q == CW'(W-1));
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last_o)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_o;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RUN_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> (cnt_q == '0)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last_o && start_i) |=> step_o); // R5
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o
);
  localparam int AW = 2*W + 1;

  logic [AW-1:0] acc_q;
  logic [W-1:0]  mcand_q;
  logic [W:0]    part_nxt;

  mul_addsub #(.W(W)) u_addsub (
    .part_i (acc_q[AW-1:W]),
    .opnd_i (mcand_q),
    .en_i   (acc_q[0]),
    .sub_i  (last_i),
    .res_o  (part_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      acc_q   <= {{(W+1){1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      // add result lands one bit right: add and arithmetic shift in one cycle
      acc_q <= {part_nxt[W], part_nxt, acc_q[W-1:1]};
    end
  end

  assign product_o = acc_q[2*W-1:0];

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(acc_q)); // R6
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q[W-1:0] == $past(mplier_i))); // R7
endmodule

// File: rtl/signed_seq_mul.sv
module signed_seq_mul #(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);
  logic load, step, last;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done_o)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
  );

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !step); // R3
endmodule

// File: tb/signed_seq_mul_bench.sv
module signed_seq_mul_bench;
  localparam int W = 4;
  localparam int NV = 8;
  // {mcand, mplier, expected product}
  localparam logic [15:0] VEC [NV] = '{
    16'h7523, 16'hD5F1, 16'h5DF1, 16'hBD0F,
    16'h8840, 16'h78C8, 16'h87C8, 16'hFF01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic [2*W-1:0] product;
  logic done;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  signed_seq_mul #(.W(W)) u_signed_seq_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .product_o(product), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // start on a negedge, return product and negedges counted until done
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [2*W-1:0] p, output int lat);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    p = product;
  endtask

  initial begin
    logic [2*W-1:0] p, p2;
    int lat;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", {product, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", {product, done}, 0);

    for (int i = 0; i < NV; i++) begin
      run_mul(VEC[i][15:12], VEC[i][11:8], p, lat);
      chk(p == VEC[i][7:0], (i == 4) ? "R8" : (i == 5) ? "R9" : (i == 6 || i == 1) ? "R10" : "R2",
          p, VEC[i][7:0]);
    end

    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        logic [2*W-1:0] e;
        e = 8'(a * b);
        run_mul(4'(a), 4'(b), p, lat);
        chk(p == e, "R2", p, e);
      end
    end

    // R3 latency and R4 single pulse
    run_mul(4'h3, 4'h6, p, lat);
    chk(lat == W + 1, "R3", lat, W + 1);
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
    // R6 hold after done
    repeat (4) @(negedge clk);
    chk(product == 8'h12, "R6", product, 8'h12);

    // R5 start during run ignored, R7 operands changed during run
    @(negedge clk);
    mcand = 4'h5; mplier = 4'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mcand = 4'h9; mplier = 4'hA;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == W + 1, "R5", lat, W + 1);
    chk(product == 8'h23, "R7", product, 8'h23);
    @(negedge clk);
    chk(done == 1'b0, "R5", done, 0);
    repeat (3) @(negedge clk);
    chk(product == 8'h23, "R6", product, 8'h23);

    // back-to-back run after reset in the middle of a run
    @(negedge clk);
    mcand = 4'h7; mplier = 4'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1", {product, done}, 0);
    rst_n = 1'b1;
    run_mul(4'h8, 4'h8, p2, lat);
    chk(p2 == 8'h40, "R8", p2, 8'h40);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule